// File: doc/BRIEF.md
# Text Raster Scan Timing Generator

This block derives the complete scan timing of a character-cell text display from the two quadrature phases of a processor bus clock. Both phases are sampled on a fast system clock `clk`. A change of their exclusive-OR marks a dot. Every fourth rising edge of the E phase marks the start of a new character cell, which is eight dots wide. A single binary scan counter advances once per cell. Its low bits give the cell column, its middle bits give the dot row inside a character, and its high bits give the character line.

From that counter the block outputs the frame-RAM address and the dot-row index that drive a character generator. It also produces level flags that blank the retrace columns and the retrace line. Single-cycle pulses mark the end of each dot row (the horizontal sweep trigger), the end of the frame and the completion of the first character line. A separate vertical sweep trigger fires at the end of the frame or on a rising edge of an external dual-display restart input. The sweep one-shots themselves sit outside the block.

Top module: `text_scan_timer`

## Requirements
- R1: `dotStrobe` is a one-cycle pulse produced for each rising edge of (E XOR Q). It appears at the second `clk` edge after the input change, so each E period gives two dot strobes.
- R2: `cellStrobe` is a one-cycle pulse on every fourth rising edge of E, counted from reset. It has the same two-edge latency as R1, so each cell spans eight dot strobes.
- R3: The 12-bit scan counter advances by one in the cycle `cellStrobe` rises, holds at all other times, and wraps from 4095 to 0.
- R4: The counter is split into column = bits [4:0], dot row = bits [7:5] and line = bits [11:8]. `ramAddr` = {line, column} (9 bits) and `dotRow` = dot row.
- R5: `hBlank` is high exactly while the column is 30 or 31.
- R6: `vBlank` is high exactly while the line is 15.
- R7: `rowEndPulse` is high for one cycle, together with `cellStrobe`, whenever the column has just wrapped to 0.
- R8: `frameEndPulse` is high for one cycle, together with `cellStrobe`, when the whole counter has just wrapped to 0.
- R9: `vSweepTrig` is high for one cycle when `frameEndPulse` is high, and at the second edge after a rising edge of `dualResetIn`. If both causes fall in the same cycle, it gives one single-cycle pulse.
- R10: `firstLinePulse` is high for one cycle, together with `cellStrobe`, when the counter has just reached 256 (line 1, row 0, column 0).
- R11: A synchronous `rst` clears the counter, the cell divider and every pulse output. After release, the next cell strobe again needs four E rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the quarter-phase rate of E/Q |
| rst | input | 1 | Synchronous active-high reset |
| eClk | input | 1 | Bus clock phase E |
| qClk | input | 1 | Bus clock phase Q, a quarter period ahead of E |
| dualResetIn | input | 1 | External dual-display restart, rising-edge sensitive |
| dotStrobe | output | 1 | Dot-rate pulse |
| cellStrobe | output | 1 | Character-cell pulse |
| ramAddr | output | 9 | Frame-RAM address {line, column} |
| dotRow | output | 3 | Dot row being scanned |
| hBlank | output | 1 | Horizontal retrace blanking |
| vBlank | output | 1 | Vertical retrace blanking |
| rowEndPulse | output | 1 | Horizontal sweep trigger at the end of a dot row |
| frameEndPulse | output | 1 | End-of-frame pulse |
| vSweepTrig | output | 1 | Vertical sweep trigger |
| firstLinePulse | output | 1 | First character line has been traced |

## Verification
The vertical sweep trigger has two sources that can fire in the same cycle: the counter wrap at the end of the frame and the external restart edge. The bench tracks its own cell count. It raises `dualResetIn` on exactly the E edge that completes the 4096th cell, so both requests reach the output register in one cycle, and it expects one pulse, not two and not a stretched one. Other restart edges are placed mid-frame, where only the external source is active. Row-end, frame-end and first-line pulses are checked against the same count on every cycle of a full frame.

// File: rtl/text_scan_pkg.sv
package text_scan_pkg;

  // Strobes passed from the phase control to the scan datapath.
  typedef struct packed {
    logic dotTick;     // rising edge of E xor Q seen this cycle
    logic cellTick;    // fourth E rising edge: advance the scan counter
    logic extRestart;  // rising edge of the external restart input
  } scanStrobe_t;

  localparam int DEF_COL_W        = 5;
  localparam int DEF_ROW_W        = 3;
  localparam int DEF_LINE_W       = 4;
  localparam int DEF_CELL_DIV     = 4;
  localparam int DEF_HBLANK_COLS  = 2;
  localparam int DEF_VBLANK_LINES = 1;

endpackage

// File: rtl/scan_phase_ctrl.sv
module scan_phase_ctrl
  import text_scan_pkg::*;
#(
  parameter int CELL_DIV = DEF_CELL_DIV
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        eClk,
  input  logic        qClk,
  input  logic        extIn,
  output scanStrobe_t strobes
);

  localparam int DIV_W = (CELL_DIV > 2) ? $clog2(CELL_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CELL_DIV - 1);

  logic eSync, qSync, eLast, xLast, extSync, extLast;
  logic [DIV_W-1:0] divCnt;
  logic xNow, eRise, divWrap;

  assign xNow    = eSync ^ qSync;
  assign eRise   = eSync & ~eLast;
  assign divWrap = (divCnt == DIV_LAST);

  always_comb begin
    strobes.dotTick    = xNow & ~xLast;
    strobes.cellTick   = eRise & divWrap;
    strobes.extRestart = extSync & ~extLast;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eSync   <= 1'b0;
      qSync   <= 1'b0;
      eLast   <= 1'b0;
      xLast   <= 1'b0;
      extSync <= 1'b0;
      extLast <= 1'b0;
      divCnt  <= '0;
    end else begin
      eSync   <= eClk;
      qSync   <= qClk;
      eLast   <= eSync;
      xLast   <= xNow;
      extSync <= extIn;
      extLast <= extSync;
      if (eRise) divCnt <= divWrap ? '0 : divCnt + 1'b1;
    end
  end

  // R1: a dot tick never lasts two cycles
  p_dot_single_r1: assert property (@(posedge clk) disable iff (rst)
    strobes.dotTick |=> !strobes.dotTick);

  // R2: a cell tick never lasts two cycles
  p_cell_single_r2: assert property (@(posedge clk) disable iff (rst)
    strobes.cellTick |=> !strobes.cellTick);

  // R11: reset leaves the divider at its start
  p_div_reset_r11: assert property (@(posedge clk)
    rst |=> (divCnt == '0));

endmodule

// File: rtl/scan_counter_path.sv
module scan_counter_path
  import text_scan_pkg::*;
#(
  parameter int COL_W        = DEF_COL_W,
  parameter int ROW_W        = DEF_ROW_W,
  parameter int LINE_W       = DEF_LINE_W,
  parameter int HBLANK_COLS  = DEF_HBLANK_COLS,
  parameter int VBLANK_LINES = DEF_VBLANK_LINES,
  localparam int CNT_W  = COL_W + ROW_W + LINE_W,
  localparam int ADDR_W = COL_W + LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  scanStrobe_t       strobes,
  output logic              dotStrobe,
  output logic              cellStrobe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [ROW_W-1:0]  dotRow,
  output logic              hBlank,
  output logic              vBlank,
  output logic              rowEndPulse,
  output logic              frameEndPulse,
  output logic              vSweepTrig,
  output logic              firstLinePulse
);

  localparam int HB_START = (1 << COL_W) - HBLANK_COLS;
  localparam int VB_START = (1 << LINE_W) - VBLANK_LINES;

  logic [CNT_W-1:0]  scanCnt;
  logic [COL_W-1:0]  column;
  logic [ROW_W-1:0]  rowIdx;
  logic [LINE_W-1:0] lineIdx;
  logic colLast, frameLast, firstLast;

  assign column  = scanCnt[COL_W-1:0];
  assign rowIdx  = scanCnt[COL_W +: ROW_W];
  assign lineIdx = scanCnt[COL_W+ROW_W +: LINE_W];

  assign colLast   = &column;
  assign frameLast = &scanCnt;
  assign firstLast = (lineIdx == '0) && (&rowIdx) && colLast;

  assign ramAddr = {lineIdx, column};
  assign dotRow  = rowIdx;

  generate
    if (HBLANK_COLS > 0) begin : g_hblank
      assign hBlank = (int'(column) >= HB_START);
    end else begin : g_no_hblank
      assign hBlank = 1'b0;
    end
    if (VBLANK_LINES > 0) begin : g_vblank
      assign vBlank = (int'(lineIdx) >= VB_START);
    end else begin : g_no_vblank
      assign vBlank = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scanCnt        <= '0;
      dotStrobe      <= 1'b0;
      cellStrobe     <= 1'b0;
      rowEndPulse    <= 1'b0;
      frameEndPulse  <= 1'b0;
      firstLinePulse <= 1'b0;
      vSweepTrig     <= 1'b0;
    end else begin
      dotStrobe      <= strobes.dotTick;
      cellStrobe     <= strobes.cellTick;
      rowEndPulse    <= strobes.cellTick & colLast;
      frameEndPulse  <= strobes.cellTick & frameLast;
      firstLinePulse <= strobes.cellTick & firstLast;
      vSweepTrig     <= (strobes.cellTick & frameLast) | strobes.extRestart;
      if (strobes.cellTick) scanCnt <= scanCnt + 1'b1;
    end
  end

  // R3: without a cell tick the counter holds
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !strobes.cellTick |=> $stable(scanCnt));

  // R7: a row-end pulse comes with a cell strobe at column 0
  p_rowend_r7: assert property (@(posedge clk) disable iff (rst)
    rowEndPulse |-> (cellStrobe && column == '0));

  // R5: retrace columns are never the column a row-end lands on
  p_hblank_r5: assert property (@(posedge clk) disable iff (rst)
    rowEndPulse |-> !hBlank);

  // R8/R9: frame end is also a row end and fires the vertical trigger
  p_frame_r8: assert property (@(posedge clk) disable iff (rst)
    frameEndPulse |-> (rowEndPulse && vSweepTrig && scanCnt == '0));

  // R10: first-line pulse lands on line 1, row 0, column 0
  p_first_r10: assert property (@(posedge clk) disable iff (rst)
    firstLinePulse |-> (lineIdx == LINE_W'(1) && rowIdx == '0 && column == '0));

  // R11: reset clears the counter
  p_reset_r11: assert property (@(posedge clk)
    rst |=> (scanCnt == '0 && !vSweepTrig));

endmodule

// File: rtl/text_scan_timer.sv
module text_scan_timer
  import text_scan_pkg::*;
#(
  parameter int COL_W        = DEF_COL_W,
  parameter int ROW_W        = DEF_ROW_W,
  parameter int LINE_W       = DEF_LINE_W,
  parameter int CELL_DIV     = DEF_CELL_DIV,
  parameter int HBLANK_COLS  = DEF_HBLANK_COLS,
  parameter int VBLANK_LINES = DEF_VBLANK_LINES
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      eClk,
  input  logic                      qClk,
  input  logic                      dualResetIn,
  output logic                      dotStrobe,
  output logic                      cellStrobe,
  output logic [COL_W+LINE_W-1:0]   ramAddr,
  output logic [ROW_W-1:0]          dotRow,
  output logic                      hBlank,
  output logic                      vBlank,
  output logic                      rowEndPulse,
  output logic                      frameEndPulse,
  output logic                      vSweepTrig,
  output logic                      firstLinePulse
);

  scanStrobe_t strobes;

  scan_phase_ctrl #(.CELL_DIV(CELL_DIV)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .eClk    (eClk),
    .qClk    (qClk),
    .extIn   (dualResetIn),
    .strobes (strobes)
  );

  scan_counter_path #(
    .COL_W        (COL_W),
    .ROW_W        (ROW_W),
    .LINE_W       (LINE_W),
    .HBLANK_COLS  (HBLANK_COLS),
    .VBLANK_LINES (VBLANK_LINES)
  ) u_path (
    .clk            (clk),
    .rst            (rst),
    .strobes        (strobes),
    .dotStrobe      (dotStrobe),
    .cellStrobe     (cellStrobe),
    .ramAddr        (ramAddr),
    .dotRow         (dotRow),
    .hBlank         (hBlank),
    .vBlank         (vBlank),
    .rowEndPulse    (rowEndPulse),
    .frameEndPulse  (frameEndPulse),
    .vSweepTrig     (vSweepTrig),
    .firstLinePulse (firstLinePulse)
  );

endmodule

// File: tb/text_scan_timer_tb.sv
module text_scan_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME_CELLS = 4096;

  logic clk = 1'b0;
  logic rst, eClk, qClk, dualResetIn;
  logic dotStrobe, cellStrobe, hBlank, vBlank;
  logic rowEndPulse, frameEndPulse, vSweepTrig, firstLinePulse;
  logic [8:0] ramAddr;
  logic [2:0] dotRow;

  always #(CLK_PERIOD/2) clk = ~clk;

  text_scan_timer u_dut (
    .clk(clk), .rst(rst), .eClk(eClk), .qClk(qClk), .dualResetIn(dualResetIn),
    .dotStrobe(dotStrobe), .cellStrobe(cellStrobe), .ramAddr(ramAddr),
    .dotRow(dotRow), .hBlank(hBlank), .vBlank(vBlank),
    .rowEndPulse(rowEndPulse), .frameEndPulse(frameEndPulse),
    .vSweepTrig(vSweepTrig), .firstLinePulse(firstLinePulse)
  );

  int errors = 0;
  int checks = 0;
  int modelCnt, risesSinceCell, dotsSinceCell, cellsSeen, phase, holdCnt;
  int extHold, stepNo;
  bit cellPipe0, cellPipe1, dotPipe0, dotPipe1, extPipe0, extPipe1;
  bit cellsStarted, coincideDone;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    modelCnt = 0; risesSinceCell = 0; dotsSinceCell = 0; phase = 0; holdCnt = 0;
    cellPipe0 = 0; cellPipe1 = 0; dotPipe0 = 0; dotPipe1 = 0;
    extPipe0 = 0; extPipe1 = 0; extHold = 0; cellsStarted = 0;
  endtask

  task automatic checkIdle(input string req);
    chk(ramAddr == 0, {req, " ramAddr"}, ramAddr, 0);
    chk(dotRow == 0, {req, " dotRow"}, dotRow, 0);
    chk(!cellStrobe && !dotStrobe, {req, " strobes"}, cellStrobe, 0);
    chk(!rowEndPulse && !frameEndPulse && !vSweepTrig && !firstLinePulse,
        {req, " pulses"}, vSweepTrig, 0);
    chk(!hBlank && !vBlank, {req, " blanks"}, hBlank, 0);
  endtask

  // One negedge: check outputs against the model, then drive the next inputs.
  task automatic step(input bit wantExt);
    bit expCell, expDot, expExt, expFrame;
    int col, row, line;
    bit eRiseNow, xRiseNow;
    @(negedge clk);
    stepNo++;
    expCell = cellPipe1; expDot = dotPipe1; expExt = extPipe1;
    cellPipe1 = cellPipe0; dotPipe1 = dotPipe0; extPipe1 = extPipe0;
    cellPipe0 = 0; dotPipe0 = 0; extPipe0 = 0;
    if (expCell) begin
      modelCnt = (modelCnt + 1) % FRAME_CELLS;
      cellsSeen++;
      // R2: eight dot strobes per cell (first cell after reset is partial)
      if (cellsStarted) chk(dotsSinceCell == 8, "R2 dots per cell", dotsSinceCell, 8);
      cellsStarted = 1;
      dotsSinceCell = 0;
    end
    if (dotStrobe) dotsSinceCell++;
    col = modelCnt % 32; row = (modelCnt / 32) % 8; line = modelCnt / 256;
    expFrame = expCell && modelCnt == 0;
    chk(dotStrobe == expDot, "R1 dotStrobe", dotStrobe, expDot);
    chk(cellStrobe == expCell, "R2 cellStrobe", cellStrobe, expCell);
    chk(ramAddr == 9'(line * 32 + col), "R3 R4 ramAddr", ramAddr, line * 32 + col);
    chk(dotRow == 3'(row), "R4 dotRow", dotRow, row);
    chk(hBlank == (col >= 30), "R5 hBlank", hBlank, col >= 30);
    chk(vBlank == (line == 15), "R6 vBlank", vBlank, line == 15);
    chk(rowEndPulse == (expCell && col == 0), "R7 rowEndPulse", rowEndPulse, expCell && col == 0);
    chk(frameEndPulse == expFrame, "R8 frameEndPulse", frameEndPulse, expFrame);
    chk(vSweepTrig == (expFrame || expExt), "R9 vSweepTrig", vSweepTrig, expFrame || expExt);
    if (expFrame && expExt) chk(vSweepTrig == 1'b1, "R9 coincident trigger", vSweepTrig, 1);
    chk(firstLinePulse == (expCell && modelCnt == 256), "R10 firstLinePulse",
        firstLinePulse, expCell && modelCnt == 256);

    // drive next quarter phase: 00 -> 01 -> 11 -> 10
    eRiseNow = 0; xRiseNow = 0;
    holdCnt++;
    if (holdCnt == 2) begin
      holdCnt = 0;
      phase = (phase + 1) % 4;
      xRiseNow = (phase == 1) || (phase == 3);
      eRiseNow = (phase == 2);
    end
    eClk = (phase == 2) || (phase == 3);
    qClk = (phase == 1) || (phase == 2);
    if (xRiseNow) dotPipe0 = 1;
    if (eRiseNow) begin
      risesSinceCell++;
      if (risesSinceCell == 4) begin
        risesSinceCell = 0;
        cellPipe0 = 1;
        // R9: external restart on the very edge that ends the frame
        if (modelCnt == FRAME_CELLS - 1 && !coincideDone && extHold == 0) begin
          coincideDone = 1;
          wantExt = 1;
        end
      end
    end
    if (extHold > 0) begin
      extHold--;
      if (extHold == 0) dualResetIn = 0;
    end else if (wantExt && !dualResetIn) begin
      dualResetIn = 1;
      extPipe0 = 1;
      extHold = 3;
    end
  endtask

  initial begin
    rst = 1; eClk = 0; qClk = 0; dualResetIn = 0;
    stepNo = 0; cellsSeen = 0; coincideDone = 0;
    modelReset();
    repeat (2) @(negedge clk);
    checkIdle("R11 reset state");
    rst = 0;
    while (cellsSeen < FRAME_CELLS + 8)
      step(stepNo == 3000 || stepNo == 70001 || stepNo == 100123);
    chk(coincideDone, "R9 coincidence provoked", coincideDone, 1);

    // R11: reset in mid-run
    @(negedge clk);
    rst = 1; eClk = 0; qClk = 0; dualResetIn = 0;
    @(negedge clk);
    checkIdle("R11 mid-run reset");
    rst = 0;
    modelReset();
    cellsSeen = 0;
    while (cellsSeen < 6) step(1'b0);
    chk(ramAddr == 9'd6, "R11 count after reset", ramAddr, 6);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", stepNo, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule